// File: doc/BRIEF.md
# Parallel Expansion Bus Controller

This block sits between an internal request port and an external parallel bus with one chip select. Each accepted read or write is turned into a bus cycle. The cycle always walks through five phases in the same order: address, chip-select setup, strobe, hold and recovery. Each phase normally lasts one clock. A programmed count can lengthen each phase on its own. The address, setup and hold phases can each grow by up to 3 clocks, and the strobe and recovery phases by up to 15 clocks.

Mode inputs set the shape of the access:
- The external data path is 16 bits wide, or 8 bits when the narrow mode is selected.
- The address can be sent over the data lines during the address phase.
- Writes can be forbidden.
- A single byte can be read from a 16-bit device, with the low address bit picking the lane.

An access that is forbidden runs no bus cycle and is answered with an error flag. The timing and mode inputs are sampled when a request is accepted, so changing them during an access does not affect that access.

The internal side is a valid/ready request port plus a one-cycle response pulse that carries read data and an error flag. Only one access is in flight at a time. A new request can be accepted in the same cycle as the response to the previous one.

Top module: `exbus_ctrl`

## Requirements
- R1: An accepted, permitted access runs the phases address, setup, strobe, hold, recovery in that order, starting in the cycle after acceptance. Each phase lasts 1 + its programmed extension. The extension inputs are 2 bits wide for address, setup and hold, and 4 bits wide for strobe and recovery. `bus_addr` carries the request address in every phase and is zero while idle.
- R2: `resp_valid` is high for exactly one cycle. For a bus access, that cycle directly follows the last recovery cycle, so an access with all extensions zero responds 6 cycles after its acceptance edge.
- R3: `bus_cs_n` is low exactly during the setup, strobe and hold phases. `bus_rd_n` (for a read) or `bus_wr_n` (for a write) is low exactly during the strobe phase. The two strobes are never low together.
- R4: Read data is the value of `bus_din` during the last strobe cycle. On a full 16-bit read it is returned unchanged.
- R5: With `cfg_narrow`=1, writes drive `{8'h00, wdata[7:0]}` and reads return `{8'h00, din[7:0]}`.
- R6: On a 16-bit bus with `cfg_byte_half`=1, a read with `req_byte`=1 returns `{8'h00, din[15:8]}` when address bit 0 is 1, and `{8'h00, din[7:0]}` when it is 0. `req_byte` has no effect on writes.
- R7: On a 16-bit bus with `cfg_byte_half`=0, a read with `req_byte`=1 runs no bus cycle and responds with `resp_err`=1 in the cycle after acceptance.
- R8: With `cfg_wr_en`=0, a write runs no bus cycle (`bus_cs_n` stays high) and responds with `resp_err`=1 in the cycle after acceptance.
- R9: With `cfg_mux`=1, `bus_doe` is high during the address phase and `bus_dout` carries `req_addr[15:0]`.
- R10: On writes, `bus_doe` is high and `bus_dout` carries the write data from setup through hold. Apart from R9, `bus_doe` is low at all other times.
- R11: `req_ready` is high only when no access is in progress, including the response cycle. The bus is quiet whenever `req_ready` is high.
- R12: Timing and mode inputs are sampled at acceptance. Changes made during an access affect only later accesses.
- R13: During reset and for two clocks after `rst_n` rises, `req_ready`, `resp_valid` and `bus_doe` are low, `bus_cs_n`, `bus_rd_n` and `bus_wr_n` are high, and `bus_addr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr_ext | input | 2 | Extra address-phase clocks |
| cfg_setup_ext | input | 2 | Extra setup-phase clocks |
| cfg_strobe_ext | input | 4 | Extra strobe-phase clocks |
| cfg_hold_ext | input | 2 | Extra hold-phase clocks |
| cfg_recov_ext | input | 4 | Extra recovery-phase clocks |
| cfg_narrow | input | 1 | 1: 8-bit external data, 0: 16-bit |
| cfg_mux | input | 1 | Address sent on the data lines in the address phase |
| cfg_wr_en | input | 1 | Writes permitted |
| cfg_byte_half | input | 1 | Byte reads allowed on a 16-bit bus |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1: write, 0: read |
| req_byte | input | 1 | Byte read request |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_err | output | 1 | Access refused |
| resp_rdata | output | DATA_W | Read data, zero on error |
| bus_addr | output | ADDR_W | External address |
| bus_dout | output | DATA_W | External data driven out |
| bus_doe | output | 1 | Output enable for `bus_dout` |
| bus_din | input | DATA_W | External data in |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |

## Verification
Bus outputs follow a fixed schedule.
- They change at the first edge after acceptance, and each phase then occupies exactly 1 + extension clocks.
- A refused request answers one cycle after acceptance.
- A completed access answers one cycle after its last recovery clock.
- Read data reflects `bus_din` as it stood in the final strobe clock.

The bench builds a queue of the expected port values, one entry per cycle, at the acceptance edge, using the mode values sampled then. It compares every output on the falling edge of every cycle, so each result is checked in the exact cycle it is due. Because `bus_din` changes every cycle, a capture in the wrong clock shows up as a data mismatch.

// File: rtl/exbus_pkg.sv
package exbus_pkg;

  localparam int SHORT_W = 2;
  localparam int LONG_W  = 4;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD,
    PH_RECOV
  } phase_e;

  // Extensions for the phases after the address phase, captured at accept.
  typedef struct packed {
    logic [SHORT_W-1:0] t_setup;
    logic [LONG_W-1:0]  t_strobe;
    logic [SHORT_W-1:0] t_hold;
    logic [LONG_W-1:0]  t_recov;
  } late_timing_t;

endpackage

// File: rtl/exbus_phase_seq.sv
module exbus_phase_seq
  import exbus_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [SHORT_W-1:0] first_ext,
  input  late_timing_t       timing,
  output phase_e             phase,
  output logic               phase_last,
  output logic               done
);

  phase_e              phase_q, phase_d;
  logic [LONG_W-1:0]   cnt_q, cnt_d;
  logic                seq_en;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    if (phase_q == PH_IDLE) begin
      if (start) begin
        phase_d = PH_ADDR;
        cnt_d   = LONG_W'(first_ext);
      end
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end else begin
      case (phase_q)
        PH_ADDR: begin
          phase_d = PH_SETUP;
          cnt_d   = LONG_W'(timing.t_setup);
        end
        PH_SETUP: begin
          phase_d = PH_STROBE;
          cnt_d   = timing.t_strobe;
        end
        PH_STROBE: begin
          phase_d = PH_HOLD;
          cnt_d   = LONG_W'(timing.t_hold);
        end
        PH_HOLD: begin
          phase_d = PH_RECOV;
          cnt_d   = timing.t_recov;
        end
        default: begin
          phase_d = PH_IDLE;
          cnt_d   = '0;
        end
      endcase
    end
  end

  assign seq_en = start | (phase_q != PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (seq_en) begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign phase      = phase_q;
  assign phase_last = (phase_q != PH_IDLE) && (cnt_q == '0);
  assign done       = (phase_q == PH_RECOV) && (cnt_q == '0);

endmodule

// File: rtl/exbus_lane_io.sv
module exbus_lane_io
  import exbus_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase,
  input  logic              phase_last,
  input  logic              is_wr,
  input  logic              is_byte,
  input  logic              narrow,
  input  logic              mux,
  input  logic [DATA_W-1:0] addr_lo,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              doe,
  output logic [DATA_W-1:0] rdata
);

  localparam int LANE_W = DATA_W / 2;
  localparam int PAD_W  = DATA_W - LANE_W;

  logic [DATA_W-1:0] wr_lane;
  logic [DATA_W-1:0] rd_lane;
  logic [DATA_W-1:0] rdata_q;
  logic              cap_en;

  always_comb begin
    if (narrow) wr_lane = {{PAD_W{1'b0}}, wdata[LANE_W-1:0]};
    else        wr_lane = wdata;
  end

  always_comb begin
    if (narrow)
      rd_lane = {{PAD_W{1'b0}}, din[LANE_W-1:0]};
    else if (is_byte && addr_lo[0])
      rd_lane = {{PAD_W{1'b0}}, din[DATA_W-1:LANE_W]};
    else if (is_byte)
      rd_lane = {{PAD_W{1'b0}}, din[LANE_W-1:0]};
    else
      rd_lane = din;
  end

  always_comb begin
    doe  = 1'b0;
    dout = '0;
    case (phase)
      PH_ADDR: begin
        if (mux) begin
          doe  = 1'b1;
          dout = addr_lo;
        end
      end
      PH_SETUP, PH_STROBE, PH_HOLD: begin
        if (is_wr) begin
          doe  = 1'b1;
          dout = wr_lane;
        end
      end
      default: ;
    endcase
  end

  assign cap_en = (phase == PH_STROBE) && phase_last && !is_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (cap_en) rdata_q <= rd_lane;
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/exbus_ctrl.sv
module exbus_ctrl
  import exbus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SHORT_W-1:0] cfg_addr_ext,
  input  logic [SHORT_W-1:0] cfg_setup_ext,
  input  logic [LONG_W-1:0]  cfg_strobe_ext,
  input  logic [SHORT_W-1:0] cfg_hold_ext,
  input  logic [LONG_W-1:0]  cfg_recov_ext,
  input  logic               cfg_narrow,
  input  logic               cfg_mux,
  input  logic               cfg_wr_en,
  input  logic               cfg_byte_half,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic               req_byte,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               resp_valid,
  output logic               resp_err,
  output logic [DATA_W-1:0]  resp_rdata,
  output logic [ADDR_W-1:0]  bus_addr,
  output logic [DATA_W-1:0]  bus_dout,
  output logic               bus_doe,
  input  logic [DATA_W-1:0]  bus_din,
  output logic               bus_cs_n,
  output logic               bus_rd_n,
  output logic               bus_wr_n
);

  // Reset: asserted asynchronously, released through two flops.
  logic rst_meta, rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta  <= 1'b0;
      rst_n_int <= 1'b0;
    end else begin
      rst_meta  <= 1'b1;
      rst_n_int <= rst_meta;
    end
  end

  phase_e       phase;
  logic         phase_last;
  logic         done;
  late_timing_t timing_live, timing_q;
  logic         narrow_q, mux_q;
  logic         wr_q, byte_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata;
  logic         accept, refuse, start;
  logic         resp_v_q, resp_v_d, resp_e_q, resp_e_d;

  always_comb begin
    timing_live.t_setup  = cfg_setup_ext;
    timing_live.t_strobe = cfg_strobe_ext;
    timing_live.t_hold   = cfg_hold_ext;
    timing_live.t_recov  = cfg_recov_ext;
  end

  assign req_ready = rst_n_int && (phase == PH_IDLE);
  assign accept    = req_valid && req_ready;
  assign refuse    = (req_write && !cfg_wr_en) ||
                     (!req_write && req_byte && !cfg_narrow && !cfg_byte_half);
  assign start     = accept && !refuse;

  // Request and mode snapshot, enabled by acceptance.
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      timing_q <= '0;
      narrow_q <= 1'b0;
      mux_q    <= 1'b0;
      wr_q     <= 1'b0;
      byte_q   <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
    end else if (accept) begin
      timing_q <= timing_live;
      narrow_q <= cfg_narrow;
      mux_q    <= cfg_mux;
      wr_q     <= req_write;
      byte_q   <= req_byte && !req_write;
      addr_q   <= req_addr;
      wdata_q  <= req_wdata;
    end
  end

  exbus_phase_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .start      (start),
    .first_ext  (cfg_addr_ext),
    .timing     (timing_q),
    .phase      (phase),
    .phase_last (phase_last),
    .done       (done)
  );

  exbus_lane_io #(.DATA_W(DATA_W)) u_lane (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .phase      (phase),
    .phase_last (phase_last),
    .is_wr      (wr_q),
    .is_byte    (byte_q),
    .narrow     (narrow_q),
    .mux        (mux_q),
    .addr_lo    (addr_q[DATA_W-1:0]),
    .wdata      (wdata_q),
    .din        (bus_din),
    .dout       (bus_dout),
    .doe        (bus_doe),
    .rdata      (rdata)
  );

  // Response pulse.
  always_comb begin
    resp_v_d = (accept && refuse) || done;
    resp_e_d = accept && refuse;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      resp_v_q <= 1'b0;
      resp_e_q <= 1'b0;
    end else begin
      resp_v_q <= resp_v_d;
      resp_e_q <= resp_e_d;
    end
  end

  assign resp_valid = resp_v_q;
  assign resp_err   = resp_e_q;
  assign resp_rdata = (resp_v_q && !resp_e_q) ? rdata : '0;

  // Bus control decode.
  assign bus_addr = (phase != PH_IDLE) ? addr_q : '0;
  assign bus_cs_n = !((phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD));
  assign bus_rd_n = !((phase == PH_STROBE) && !wr_q);
  assign bus_wr_n = !((phase == PH_STROBE) && wr_q);

endmodule

// File: rtl/exbus_ctrl_chk.sv
module exbus_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic req_write,
  input logic cfg_wr_en,
  input logic resp_valid,
  input logic resp_err,
  input logic bus_cs_n,
  input logic bus_rd_n,
  input logic bus_wr_n,
  input logic bus_doe
);

  assert_strobe_in_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd_n || !bus_wr_n) |-> !bus_cs_n);

  assert_single_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_wr_n));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (bus_cs_n && bus_rd_n && bus_wr_n && !bus_doe));

  assert_busy_after_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write && cfg_wr_en) |=> !req_ready);

  assert_write_refused_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write && !cfg_wr_en) |=> (resp_valid && resp_err && bus_cs_n));

  assert_write_drives_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr_n |-> bus_doe);

  assert_resp_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> req_ready);

endmodule

bind exbus_ctrl exbus_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_write  (req_write),
  .cfg_wr_en  (cfg_wr_en),
  .resp_valid (resp_valid),
  .resp_err   (resp_err),
  .bus_cs_n   (bus_cs_n),
  .bus_rd_n   (bus_rd_n),
  .bus_wr_n   (bus_wr_n),
  .bus_doe    (bus_doe)
);

// File: tb/sim_exbus_ctrl.sv
module sim_exbus_ctrl;

  localparam int AW = 20;
  localparam int DW = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n;
  logic [1:0]    cfg_addr_ext, cfg_setup_ext, cfg_hold_ext;
  logic [3:0]    cfg_strobe_ext, cfg_recov_ext;
  logic          cfg_narrow, cfg_mux, cfg_wr_en, cfg_byte_half;
  logic          req_valid, req_ready, req_write, req_byte;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          resp_valid, resp_err;
  logic [DW-1:0] resp_rdata;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_dout, bus_din;
  logic          bus_doe, bus_cs_n, bus_rd_n, bus_wr_n;

  exbus_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_addr_ext(cfg_addr_ext), .cfg_setup_ext(cfg_setup_ext),
    .cfg_strobe_ext(cfg_strobe_ext), .cfg_hold_ext(cfg_hold_ext),
    .cfg_recov_ext(cfg_recov_ext), .cfg_narrow(cfg_narrow), .cfg_mux(cfg_mux),
    .cfg_wr_en(cfg_wr_en), .cfg_byte_half(cfg_byte_half),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_byte(req_byte), .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_err(resp_err), .resp_rdata(resp_rdata),
    .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din),
    .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n)
  );

  typedef struct {
    logic          cs_n, rd_n, wr_n, doe, ready, rv, rerr, rdchk;
    logic [DW-1:0] dout, rdata;
    logic [AW-1:0] addr;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  int   cyc    = 0;
  bit   cmp_en = 1'b0;
  bit   m_rdy, m_acc;
  exp_t cur;

  function automatic logic [DW-1:0] din_of(int n);
    return DW'(n * 933) ^ 16'h5c00;
  endfunction

  function automatic exp_t idle_e();
    exp_t e;
    e.cs_n = 1'b1; e.rd_n = 1'b1; e.wr_n = 1'b1; e.doe = 1'b0;
    e.ready = 1'b1; e.rv = 1'b0; e.rerr = 1'b0; e.rdchk = 1'b0;
    e.dout = '0; e.rdata = '0; e.addr = '0;
    return e;
  endfunction

  // Builds the per-cycle expectation from the values present at acceptance.
  function automatic void push_access(logic w, logic b, logic [AW-1:0] a,
                                      logic [DW-1:0] d, int n0);
    int ext[5];
    int sum;
    exp_t e;
    logic [DW-1:0] cap, rd;
    if ((w && !cfg_wr_en) || (!w && b && !cfg_narrow && !cfg_byte_half)) begin
      e = idle_e(); e.rv = 1'b1; e.rerr = 1'b1;
      q.push_back(e);
      return;
    end
    ext[0] = int'(cfg_addr_ext);   ext[1] = int'(cfg_setup_ext);
    ext[2] = int'(cfg_strobe_ext); ext[3] = int'(cfg_hold_ext);
    ext[4] = int'(cfg_recov_ext);
    sum = ext[0] + ext[1] + ext[2] + 3;
    cap = din_of(n0 + sum);
    if (cfg_narrow)           rd = {8'h00, cap[7:0]};
    else if (b && a[0])       rd = {8'h00, cap[15:8]};
    else if (b)               rd = {8'h00, cap[7:0]};
    else                      rd = cap;
    for (int ph = 0; ph < 5; ph++) begin
      for (int k = 0; k <= ext[ph]; k++) begin
        e = idle_e();
        e.ready = 1'b0;
        e.addr  = a;
        e.cs_n  = !(ph >= 1 && ph <= 3);
        e.rd_n  = !(ph == 2 && !w);
        e.wr_n  = !(ph == 2 && w);
        if (ph == 0 && cfg_mux) begin
          e.doe = 1'b1; e.dout = a[DW-1:0];
        end else if (w && ph >= 1 && ph <= 3) begin
          e.doe = 1'b1; e.dout = cfg_narrow ? {8'h00, d[7:0]} : d;
        end
        q.push_back(e);
      end
    end
    e = idle_e(); e.rv = 1'b1; e.rdchk = !w; e.rdata = rd;
    q.push_back(e);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cyc=%0d actual=%h expected=%h", tag, cyc, act, exp);
    end
  endtask

  // Reference model: advance one cycle per rising edge.
  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
    end else begin
      m_rdy = (q.size() == 0) || q[0].rv;
      m_acc = req_valid && m_rdy;
      if (q.size() != 0) void'(q.pop_front());
      if (m_acc) push_access(req_write, req_byte, req_addr, req_wdata, cyc);
    end
    cyc++;
  end

  always @(negedge clk) bus_din <= din_of(cyc);

  // Compare every port on the falling edge.
  always @(negedge clk) begin
    if (cmp_en) begin
      cur = (q.size() != 0) ? q[0] : idle_e();
      chk("R11 req_ready", 32'(req_ready), 32'(cur.ready));
      chk("R1/R3 bus_cs_n", 32'(bus_cs_n), 32'(cur.cs_n));
      chk("R1/R3 bus_rd_n", 32'(bus_rd_n), 32'(cur.rd_n));
      chk("R1/R3 bus_wr_n", 32'(bus_wr_n), 32'(cur.wr_n));
      chk("R1 bus_addr", 32'(bus_addr), 32'(cur.addr));
      chk("R9/R10 bus_doe", 32'(bus_doe), 32'(cur.doe));
      if (cur.doe) chk("R5/R9/R10 bus_dout", 32'(bus_dout), 32'(cur.dout));
      chk("R2 resp_valid", 32'(resp_valid), 32'(cur.rv));
      if (cur.rv) chk("R7/R8 resp_err", 32'(resp_err), 32'(cur.rerr));
      if (cur.rdchk) chk("R4/R5/R6 resp_rdata", 32'(resp_rdata), 32'(cur.rdata));
    end
  end

  task automatic set_cfg(int a, int s, int st, int h, int r,
                         bit nar, bit mx, bit wen, bit bh);
    cfg_addr_ext = 2'(a); cfg_setup_ext = 2'(s); cfg_strobe_ext = 4'(st);
    cfg_hold_ext = 2'(h); cfg_recov_ext = 4'(r);
    cfg_narrow = nar; cfg_mux = mx; cfg_wr_en = wen; cfg_byte_half = bh;
  endtask

  task automatic do_req(logic w, logic b, logic [AW-1:0] a, logic [DW-1:0] d, bit no_wait);
    if (!no_wait) @(negedge clk);
    req_valid = 1'b1; req_write = w; req_byte = b; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (q.size() != 0) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_byte = 1'b0;
    req_addr = '0; req_wdata = '0;
    set_cfg(0, 0, 0, 0, 0, 0, 0, 1, 0);
    repeat (3) @(negedge clk);
    // R13: quiet outputs while reset is held.
    chk("R13 ready", 32'(req_ready), 0);
    chk("R13 cs_n", 32'(bus_cs_n), 1);
    chk("R13 rd_n", 32'(bus_rd_n), 1);
    chk("R13 wr_n", 32'(bus_wr_n), 1);
    chk("R13 doe", 32'(bus_doe), 0);
    chk("R13 resp_valid", 32'(resp_valid), 0);
    chk("R13 addr", 32'(bus_addr), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R13 ready after release", 32'(req_ready), 0);
    repeat (2) @(negedge clk);
    cmp_en = 1'b1;

    // Minimal timing, 16-bit read and write (R1, R2, R4).
    do_req(0, 0, 20'h00012, 16'h0000, 0); wait_idle();
    do_req(1, 0, 20'h0a0b4, 16'hbeef, 0); wait_idle();
    // Long phases.
    set_cfg(3, 2, 15, 1, 15, 0, 0, 1, 0);
    do_req(0, 0, 20'h3fffe, 16'h0000, 0); wait_idle();
    do_req(1, 1, 20'h00101, 16'h1234, 0); wait_idle();   // R6: byte flag ignored on write
    // Narrow bus (R5).
    set_cfg(1, 0, 2, 0, 1, 1, 0, 1, 0);
    do_req(1, 0, 20'h00044, 16'hc3a5, 0); wait_idle();
    do_req(0, 0, 20'h00045, 16'h0000, 0); wait_idle();
    // Byte reads on 16-bit bus (R6), and refused (R7).
    set_cfg(0, 1, 1, 1, 0, 0, 0, 1, 1);
    do_req(0, 1, 20'h00200, 16'h0000, 0); wait_idle();
    do_req(0, 1, 20'h00201, 16'h0000, 0); wait_idle();
    set_cfg(0, 1, 1, 1, 0, 0, 0, 1, 0);
    do_req(0, 1, 20'h00201, 16'h0000, 0); wait_idle();
    // Writes disabled (R8), then a read still runs.
    set_cfg(0, 0, 3, 0, 0, 0, 0, 0, 0);
    do_req(1, 0, 20'h00300, 16'h5555, 0); wait_idle();
    do_req(0, 0, 20'h00302, 16'h0000, 0); wait_idle();
    // Multiplexed address and data (R9).
    set_cfg(1, 1, 2, 1, 0, 0, 1, 1, 0);
    do_req(0, 0, 20'h4abcd, 16'h0000, 0); wait_idle();
    do_req(1, 0, 20'h51234, 16'h9876, 0); wait_idle();
    // Back to back: second accepted in the response cycle (R11).
    set_cfg(0, 0, 1, 0, 2, 0, 0, 1, 0);
    do_req(0, 0, 20'h00010, 16'h0000, 0);
    do_req(1, 0, 20'h00020, 16'h7777, 1);
    wait_idle();
    // R12: change timing and modes right after acceptance.
    set_cfg(2, 3, 9, 3, 5, 0, 1, 1, 0);
    do_req(1, 0, 20'h00abc, 16'h2468, 0);
    set_cfg(0, 0, 0, 0, 0, 1, 0, 0, 0);
    wait_idle();
    do_req(0, 0, 20'h00abd, 16'h0000, 0); wait_idle();
    repeat (3) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 50000);
    fails++;
    $display("FAIL watchdog expired cyc=%0d actual=running expected=finished", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule